// File: doc/BRIEF.md
# Password-Gated Memory Access Controller

This block sits between the byte-level front end of a two-wire serial slave and the memory banks inside a configurable device. For every access strobe it takes a 7-bit device address and a byte address. It decides three things: whether the target exists, which bank it selects, and whether the access may proceed. An external write-protect pin and a volatile lock bit set the protection state. Lock is on whenever the pin is low or the bit is set. It is off only when the pin is high and the bit is clear.

While the lock is on, only reads of the configuration bank (device address 1010_000) are granted. The configuration bank holds two volatile registers, the lock bit at byte 7Eh and a password byte at byte 7Fh. The lock bit accepts a write only if the volatile password equals a password stored in nonvolatile memory. The nonvolatile copy is presented to this block on an input. The memory arrays and the serial bit protocol sit outside the block. The block reports the decision, the bank index and the volatile register read data, all registered one cycle after the strobe.

Top module: `mem_access_gate`

## Requirements
- R1: An access is acknowledged only when dev_addr[6:3] is 1010 and dev_addr[2:0] is 0 to 4. bank_idx then reports dev_addr[2:0]. Any other device address gives ack = 0 and grant = 0.
- R2: Byte addresses 80h to FFh of banks 0 and 3 are not acknowledged, and no byte of bank 1 is. Every byte of banks 2 and 4 is acknowledged, and so are bytes 00h to 7Fh of banks 0 and 3.
- R3: The lock is on when wp_pin is 0 or vol_protect is 1. The pin alone locks the device even when vol_protect is 0, and vol_protect alone locks it even when wp_pin is 1.
- R4: While the lock is on, an acknowledged access is granted only if it is a read of bank 0. Every write and every read of another bank gives grant = 0 with ack = 1.
- R5: While the lock is off, every acknowledged read and write is granted.
- R6: A granted write to bank 0 byte 7Eh loads wdata[0] into vol_protect only when the volatile password equals nv_passwd. Otherwise vol_protect keeps its value.
- R7: A granted write to bank 0 byte 7Fh loads the password register. The comparison uses the new value from the next clock cycle, so a back-to-back lock-bit write is judged against it.
- R8: Reset (synchronous, active high) loads vol_protect from nv_protect, clears the password to 00h and clears ack, grant, bank_idx and rdata.
- R9: A granted read of bank 0 byte 7Fh returns rdata = 00h whatever the password holds. A granted read of byte 7Eh returns {7'b0, vol_protect}. All other reads return 00h on rdata.
- R10: ack, grant, bank_idx and rdata are registered: they reflect the strobe of the previous cycle, and a cycle without req_valid gives ack = 0 and grant = 0.
- R11: A denied or unacknowledged write changes neither vol_protect nor the password.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe, one cycle per byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| dev_addr | input | 7 | Device address (family nibble and bank field) |
| byte_addr | input | 8 | Byte address within the bank |
| wdata | input | 8 | Write data |
| wp_pin | input | 1 | External write-protect pin, low locks |
| nv_protect | input | 1 | Stored lock bit, loaded at reset |
| nv_passwd | input | 8 | Stored password compared with the volatile password |
| ack | output | 1 | Target exists (registered) |
| grant | output | 1 | Access permitted (registered) |
| bank_idx | output | 3 | Selected bank for an acknowledged access, else 0 |
| rdata | output | 8 | Read data of the volatile registers |
| vol_protect | output | 1 | Current volatile lock bit |

## Verification
The bench sets the pin low with the lock bit clear, and sets the bit after a reset with the pin high. This catches a design that ORs the lock terms wrongly or lets the bit override the pin. It writes the password in one cycle and the lock bit in the next. A design that compares against a stale password would leave the bit unchanged. It reads the password byte after loading a nonzero value, which exposes any design that echoes the password. It tries a password write while locked and then a lock-bit write, which shows a denied write that leaked into state. The boundary bytes 7Fh and 80h, bank 1, bank 5 and a foreign family nibble show decode errors as wrong acknowledges.

// File: rtl/mag_pkg.sv
package mag_pkg;

  // How much of a bank's byte range is backed by storage
  typedef enum logic [1:0] {
    SPAN_NONE = 2'd0,
    SPAN_LOW  = 2'd1,
    SPAN_FULL = 2'd2
  } span_e;

  localparam int unsigned CFG_BANK = 0;

  function automatic span_e bank_span(input int unsigned idx);
    case (idx)
      0:       return SPAN_LOW;
      1:       return SPAN_NONE;
      2:       return SPAN_FULL;
      3:       return SPAN_LOW;
      4:       return SPAN_FULL;
      default: return SPAN_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mag_addr_decode.sv
module mag_addr_decode
  import mag_pkg::*;
#(
  parameter int DEV_W     = 7,
  parameter int ADDR_W    = 8,
  parameter int BANK_W    = 3,
  parameter int NUM_BANKS = 5,
  parameter int FAMILY_ID = 10,
  parameter int PROT_OFS  = 126,
  parameter int PASS_OFS  = 127
) (
  input  logic [DEV_W-1:0]  dev_addr,
  input  logic [ADDR_W-1:0] byte_addr,
  output logic              hit,
  output logic              cfg_hit,
  output logic              prot_byte,
  output logic              pass_byte,
  output logic [BANK_W-1:0] bank_sel
);
  localparam int FAM_W = DEV_W - BANK_W;

  logic                 fam_ok;
  logic                 low_half;
  logic [NUM_BANKS-1:0] hit_vec;

  assign bank_sel = dev_addr[BANK_W-1:0];
  assign fam_ok   = (dev_addr[DEV_W-1:BANK_W] == FAM_W'(FAMILY_ID));
  assign low_half = ~byte_addr[ADDR_W-1];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam span_e SPAN = bank_span(b);
    if (SPAN == SPAN_FULL) begin : g_full
      assign hit_vec[b] = fam_ok && (bank_sel == BANK_W'(b));
    end else if (SPAN == SPAN_LOW) begin : g_low
      assign hit_vec[b] = fam_ok && (bank_sel == BANK_W'(b)) && low_half;
    end else begin : g_none
      assign hit_vec[b] = 1'b0;
    end
  end

  assign hit       = |hit_vec;
  assign cfg_hit   = hit_vec[CFG_BANK];
  assign prot_byte = cfg_hit && (byte_addr == ADDR_W'(PROT_OFS));
  assign pass_byte = cfg_hit && (byte_addr == ADDR_W'(PASS_OFS));
endmodule

// File: rtl/mag_policy.sv
module mag_policy (
  input  logic wp_pin,
  input  logic vol_protect,
  input  logic req_write,
  input  logic cfg_hit,
  output logic permit
);
  logic locked;

  // Pin low locks regardless of the bit; bit set locks regardless of the pin
  assign locked = ~wp_pin | vol_protect;
  assign permit = ~locked | (cfg_hit & ~req_write);
endmodule

// File: rtl/mag_protect_regs.sv
module mag_protect_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nv_protect,
  input  logic [DATA_W-1:0] nv_passwd,
  input  logic              wr_prot,
  input  logic              wr_pass,
  input  logic [DATA_W-1:0] wdata,
  output logic              vol_protect
);
  logic [DATA_W-1:0] passwd_q;
  logic              pass_ok;

  assign pass_ok = (passwd_q == nv_passwd);

  always_ff @(posedge clk) begin
    if (rst) begin
      vol_protect <= nv_protect;
      passwd_q    <= '0;
    end else begin
      if (wr_pass)            passwd_q    <= wdata;
      if (wr_prot && pass_ok) vol_protect <= wdata[0];
    end
  end
endmodule

// File: rtl/mem_access_gate.sv
module mem_access_gate #(
  parameter int DEV_W     = 7,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int BANK_W    = 3,
  parameter int NUM_BANKS = 5,
  parameter int FAMILY_ID = 10,
  parameter int PROT_OFS  = 126,
  parameter int PASS_OFS  = 127
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DEV_W-1:0]  dev_addr,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wp_pin,
  input  logic              nv_protect,
  input  logic [DATA_W-1:0] nv_passwd,
  output logic              ack,
  output logic              grant,
  output logic [BANK_W-1:0] bank_idx,
  output logic [DATA_W-1:0] rdata,
  output logic              vol_protect
);
  logic              hit, cfg_hit, prot_byte, pass_byte, permit;
  logic              take, wr_ok;
  logic [BANK_W-1:0] bank_sel;

  mag_addr_decode #(
    .DEV_W(DEV_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS),
    .FAMILY_ID(FAMILY_ID), .PROT_OFS(PROT_OFS), .PASS_OFS(PASS_OFS)
  ) u_decode (
    .dev_addr (dev_addr),
    .byte_addr(byte_addr),
    .hit      (hit),
    .cfg_hit  (cfg_hit),
    .prot_byte(prot_byte),
    .pass_byte(pass_byte),
    .bank_sel (bank_sel)
  );

  mag_policy u_policy (
    .wp_pin     (wp_pin),
    .vol_protect(vol_protect),
    .req_write  (req_write),
    .cfg_hit    (cfg_hit),
    .permit     (permit)
  );

  assign take  = req_valid & hit & permit;
  assign wr_ok = take & req_write;

  mag_protect_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .nv_protect (nv_protect),
    .nv_passwd  (nv_passwd),
    .wr_prot    (wr_ok & prot_byte),
    .wr_pass    (wr_ok & pass_byte),
    .wdata      (wdata),
    .vol_protect(vol_protect)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack      <= 1'b0;
      grant    <= 1'b0;
      bank_idx <= '0;
      rdata    <= '0;
    end else begin
      ack      <= req_valid & hit;
      grant    <= take;
      bank_idx <= (req_valid & hit) ? bank_sel : '0;
      // Password byte never reads back; only the lock bit is visible
      rdata    <= (take & ~req_write & prot_byte) ? DATA_W'(vol_protect) : '0;
    end
  end
endmodule

// File: rtl/mem_access_gate_chk.sv
module mem_access_gate_chk #(
  parameter int DEV_W  = 7,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [DEV_W-1:0]  dev_addr,
  input logic [ADDR_W-1:0] byte_addr,
  input logic              wp_pin,
  input logic              vol_protect,
  input logic              ack,
  input logic              grant,
  input logic [DATA_W-1:0] rdata
);
  localparam logic [DEV_W-1:0]  CFG_DEV = DEV_W'(80);
  localparam logic [ADDR_W-1:0] PROT_B  = ADDR_W'(126);
  localparam logic [ADDR_W-1:0] PASS_B  = ADDR_W'(127);

  // R1
  foreign_family_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && dev_addr[DEV_W-1:BANK_W] != (DEV_W-BANK_W)'(10)) |=> !ack);

  // R2
  grant_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> ack);

  // R4
  locked_only_cfg_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (!wp_pin || vol_protect) &&
     (req_write || dev_addr != CFG_DEV)) |=> !grant);

  // R9
  passwd_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && dev_addr == CFG_DEV && byte_addr == PASS_B)
    |=> (rdata == '0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!ack && !grant));

  // R11
  lock_bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write && dev_addr == CFG_DEV && byte_addr == PROT_B)
    |=> $stable(vol_protect));
endmodule

bind mem_access_gate mem_access_gate_chk #(
  .DEV_W(DEV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .dev_addr   (dev_addr),
  .byte_addr  (byte_addr),
  .wp_pin     (wp_pin),
  .vol_protect(vol_protect),
  .ack        (ack),
  .grant      (grant),
  .rdata      (rdata)
);

// File: tb/mem_access_gate_tb_top.sv
module mem_access_gate_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       pin;
    logic       wr;
    logic [6:0] dev;
    logic [7:0] ba;
    logic [7:0] wd;
    logic       e_ack;
    logic       e_gnt;
    logic [7:0] e_rd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 7'h50, 8'h10, 8'h00, 1'b1, 1'b1, 8'h00},  // R1 R5 bank 0 read
    '{1'b1, 1'b0, 7'h51, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00},  // R2 bank 1 absent
    '{1'b1, 1'b0, 7'h52, 8'hFF, 8'h00, 1'b1, 1'b1, 8'h00},  // R2 bank 2 top byte
    '{1'b1, 1'b1, 7'h53, 8'h7F, 8'h33, 1'b1, 1'b1, 8'h00},  // R5 write bank 3
    '{1'b1, 1'b0, 7'h53, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00},  // R2 bank 3 upper half
    '{1'b1, 1'b0, 7'h54, 8'hFF, 8'h00, 1'b1, 1'b1, 8'h00},  // R2 bank 4 top byte
    '{1'b1, 1'b0, 7'h55, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00},  // R1 bank 5
    '{1'b1, 1'b0, 7'h30, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00},  // R1 foreign family
    '{1'b0, 1'b0, 7'h50, 8'h20, 8'h00, 1'b1, 1'b1, 8'h00},  // R3 R4 pin low, bank 0 read
    '{1'b0, 1'b0, 7'h52, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00},  // R3 R4 pin low, other read
    '{1'b0, 1'b1, 7'h54, 8'h05, 8'h11, 1'b1, 1'b0, 8'h00},  // R4 pin low write
    '{1'b1, 1'b0, 7'h50, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00},  // R2 bank 0 upper half
    '{1'b0, 1'b1, 7'h50, 8'h7F, 8'h5A, 1'b1, 1'b0, 8'h00},  // R11 locked password write
    '{1'b1, 1'b0, 7'h50, 8'h7E, 8'h00, 1'b1, 1'b1, 8'h00},  // R9 lock bit reads 0
    '{1'b1, 1'b0, 7'h50, 8'h7F, 8'h00, 1'b1, 1'b1, 8'h00}   // R9 password reads 0
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [6:0] dev_addr = '0;
  logic [7:0] byte_addr = '0;
  logic [7:0] wdata = '0;
  logic       wp_pin = 1'b1;
  logic       nv_protect = 1'b0;
  logic [7:0] nv_passwd = 8'h5A;
  logic       ack, grant, vol_protect;
  logic [2:0] bank_idx;
  logic [7:0] rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_access_gate dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .dev_addr(dev_addr), .byte_addr(byte_addr), .wdata(wdata),
    .wp_pin(wp_pin), .nv_protect(nv_protect), .nv_passwd(nv_passwd),
    .ack(ack), .grant(grant), .bank_idx(bank_idx), .rdata(rdata),
    .vol_protect(vol_protect)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with outputs settled
  task automatic acc(input logic pin, input logic wr, input logic [6:0] dev,
                     input logic [7:0] ba, input logic [7:0] wd);
    wp_pin = pin; req_write = wr; dev_addr = dev; byte_addr = ba; wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset(input logic nvp);
    rst = 1'b1; nv_protect = nvp; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // R8 reset state with stored lock set
    do_reset(1'b1);
    chk("R8 vol_protect from store", 8'(vol_protect), 8'h01);
    chk("R8 ack cleared", 8'(ack), 8'h00);
    chk("R8 grant cleared", 8'(grant), 8'h00);
    chk("R8 rdata cleared", rdata, 8'h00);
    acc(1'b1, 1'b0, 7'h52, 8'h00, 8'h00);
    chk("R3 bit alone locks ack", 8'(ack), 8'h01);
    chk("R3 bit alone locks grant", 8'(grant), 8'h00);
    acc(1'b1, 1'b0, 7'h50, 8'h10, 8'h00);
    chk("R4 cfg read while locked", 8'(grant), 8'h01);

    do_reset(1'b0);
    chk("R8 vol_protect cleared from store", 8'(vol_protect), 8'h00);

    for (int i = 0; i < NV; i++) begin
      acc(VECS[i].pin, VECS[i].wr, VECS[i].dev, VECS[i].ba, VECS[i].wd);
      chk($sformatf("vec%0d ack R1 R2", i), 8'(ack), 8'(VECS[i].e_ack));
      chk($sformatf("vec%0d grant R4 R5", i), 8'(grant), 8'(VECS[i].e_gnt));
      chk($sformatf("vec%0d rdata R9", i), rdata, VECS[i].e_rd);
      chk($sformatf("vec%0d bank_idx R1", i), 8'(bank_idx),
          VECS[i].e_ack ? 8'(VECS[i].dev[2:0]) : 8'h00);
    end

    // R6 R11: password still 00h after the denied write, so the lock write is ignored
    acc(1'b1, 1'b1, 7'h50, 8'h7E, 8'h01);
    chk("R6 lock write granted", 8'(grant), 8'h01);
    chk("R11 lock bit unchanged on mismatch", 8'(vol_protect), 8'h00);

    // R7 password then lock bit back to back
    acc(1'b1, 1'b1, 7'h50, 8'h7F, 8'h5A);
    chk("R7 password write granted", 8'(grant), 8'h01);
    chk("R7 lock bit still clear", 8'(vol_protect), 8'h00);
    acc(1'b1, 1'b1, 7'h50, 8'h7E, 8'h01);
    chk("R7 R6 lock bit set after match", 8'(vol_protect), 8'h01);

    acc(1'b1, 1'b0, 7'h50, 8'h7F, 8'h00);
    chk("R9 password hidden grant", 8'(grant), 8'h01);
    chk("R9 password hidden", rdata, 8'h00);
    acc(1'b1, 1'b0, 7'h50, 8'h7E, 8'h00);
    chk("R9 lock bit readback", rdata, 8'h01);
    acc(1'b1, 1'b1, 7'h52, 8'h00, 8'h77);
    chk("R4 write denied by lock bit", 8'(grant), 8'h00);
    acc(1'b1, 1'b1, 7'h50, 8'h7E, 8'h00);
    chk("R4 R11 locked lock write denied", 8'(vol_protect), 8'h01);

    @(negedge clk);
    chk("R10 idle ack", 8'(ack), 8'h00);
    chk("R10 idle grant", 8'(grant), 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule